// File: doc/BRIEF.md
# Grouped four-level interrupt priority controller

This block sits beside a small 8-bit microcontroller core and decides which interrupt the core takes next. It keeps a request flag for each of eleven sources: seven external lines, two timers and two serial channels. A source competes only when its flag, its own enable bit and a global enable bit are all set. The sources are bound into six priority groups. Each group gets a two-bit level, and the two bits of that level sit in two separate priority registers.

Among the competing sources the highest level wins. A tie at that level goes to a fixed polling order. The winner's vector index is shown to the core together with a request line. An acknowledge clears the winner's flag and records its level in a four-bit in-service mask. A new request may interrupt the running handler only when its level is strictly above every level in service. A return strobe retires the highest level in service. While the core is stopped, external line 0 drives a wake output straight through.

Software reads and writes the enables and priorities through a byte-wide register port, and reads the flags back through the same port.

Top module: `intc_grp_prio`

## Requirements
- R1: After reset all flags, enables, both priority registers and the in-service mask are zero, and `irq_o` is low.
- R2: A high `src_i[s]` in a cycle sets flag s at the next edge. The flag then stays set until its own acknowledge. If a source strobes in the same cycle as the acknowledge that clears it, the strobe wins. Source numbering is: 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial0, 5 serial1, 6..10 ext2..ext6. The vector index equals the source number.
- R3: Source s competes only if flag s, its enable bit and the global enable are all set. The register at 0xA8 holds the enables of sources 0..6 in bits 0..6 and the global enable in bit 7. The register at 0xB8 holds the enables of sources 7..10 in bits 0..3.
- R4: Group g has level {IP1[g], IP0[g]}, with IP0 at 0xA9 and IP1 at 0xB9. Among competing sources the highest level wins. The groups are: g0 = {ext0, serial1, ext2}, g1 = {timer0, ext3}, g2 = {ext1, ext4}, g3 = {timer1, ext5}, g4 = {serial0, ext6}, and g5 has no members.
- R5: Ties at the winning level go to the lower group number. Inside a group, the first listed member beats the second, and the second beats the third.
- R6: When `ack_i` is high and `irq_o` is high, the flag of `irq_vec_o` clears and its level is added to the in-service mask. An `ack_i` while `irq_o` is low changes nothing.
- R7: `irq_o` is high only when the winning level is strictly above the highest level in service, or when nothing is in service.
- R8: `reti_i` clears the highest set bit of the in-service mask.
- R9: Bits 6 and 7 of both priority registers read back as written and have no effect on arbitration.
- R10: `wake_o` is high exactly when `stop_i` and `src_i[0]` are both high.
- R11: Address 0xC0 reads flags 0..7 and address 0xC1 reads flags 8..10 in its bits 0..2. Writes to either address are ignored. Unmapped addresses and unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 11 | Per-source request strobes |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data, combinational |
| ack_i | input | 1 | Core takes the presented vector |
| reti_i | input | 1 | Core returns from the current handler |
| stop_i | input | 1 | Core is in the stop state |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 4 | Vector index of the winning source |
| wake_o | output | 1 | Wake request from the stop state |

## Verification
The hardest situation to reach is nested service: the in-service mask holds several levels, requests are pending at and below the top level, and they must stay blocked until a return strobe exposes them. The situation gets harder when an acknowledge and a return fall in the same cycle. A directed sequence builds this up step by step. It then sends requests at exactly the in-service level, which must stay blocked, and follows with a return. A long random phase does the rest. It reprograms the priority registers at random, strobes sources sparsely and acknowledges often, and it issues returns at a lower rate than acknowledges. With returns less frequent, the mask can fill to several levels and hold there long enough to be tested.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC   = 11;
  localparam int NUM_GRP   = 6;
  localparam int NUM_LVL   = 4;
  localparam int GRP_SLOTS = 3;

  // group membership: first members 0..4 map to groups 0..4, extras trail
  function automatic int src_group(int s);
    if (s < 5)       return s;
    else if (s == 5) return 0;
    else if (s == 6) return 0;
    else             return s - 6;
  endfunction

  function automatic int src_rank(int s);
    if (s < 5)       return 0;
    else if (s == 6) return 2;
    else             return 1;
  endfunction

  function automatic int src_poll_key(int s);
    return src_group(s) * GRP_SLOTS + src_rank(s);
  endfunction
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs #(
  parameter int          NUM_SRC  = intc_pkg::NUM_SRC,
  parameter logic [7:0]  ADDR_EN0 = 8'hA8,
  parameter logic [7:0]  ADDR_EN1 = 8'hB8,
  parameter logic [7:0]  ADDR_IP0 = 8'hA9,
  parameter logic [7:0]  ADDR_IP1 = 8'hB9,
  parameter logic [7:0]  ADDR_FL0 = 8'hC0,
  parameter logic [7:0]  ADDR_FL1 = 8'hC1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [7:0]         addr_i,
  input  logic [7:0]         wdata_i,
  input  logic [NUM_SRC-1:0] flags_i,
  output logic [7:0]         rdata_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               glb_o,
  output logic [7:0]         ip0_o,
  output logic [7:0]         ip1_o
);
  localparam int LO_N = 7;
  localparam int HI_N = NUM_SRC - LO_N;
  localparam int FHI  = NUM_SRC - 8;

  logic [NUM_SRC-1:0] en_q;
  logic               glb_q;
  logic [7:0]         ip0_q, ip1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      glb_q <= 1'b0;
      ip0_q <= '0;
      ip1_q <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_EN0) begin
        en_q[LO_N-1:0] <= wdata_i[LO_N-1:0];
        glb_q          <= wdata_i[7];
      end
      if (addr_i == ADDR_EN1) en_q[NUM_SRC-1:LO_N] <= wdata_i[HI_N-1:0];
      if (addr_i == ADDR_IP0) ip0_q <= wdata_i;
      if (addr_i == ADDR_IP1) ip1_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_EN0)      rdata_o = {glb_q, en_q[LO_N-1:0]};
    else if (addr_i == ADDR_EN1) rdata_o[HI_N-1:0] = en_q[NUM_SRC-1:LO_N];
    else if (addr_i == ADDR_IP0) rdata_o = ip0_q;
    else if (addr_i == ADDR_IP1) rdata_o = ip1_q;
    else if (addr_i == ADDR_FL0) rdata_o = flags_i[7:0];
    else if (addr_i == ADDR_FL1) rdata_o[FHI-1:0] = flags_i[NUM_SRC-1:8];
  end

  assign en_o  = en_q;
  assign glb_o = glb_q;
  assign ip0_o = ip0_q;
  assign ip1_o = ip1_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(ip0_q) && $stable(ip1_q) && $stable(en_q))) else $error("cfg changed"); // R9
endmodule

// File: rtl/intc_flags.sv
module intc_flags #(
  parameter int NUM_SRC = intc_pkg::NUM_SRC,
  parameter int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_i,
  input  logic [VEC_W-1:0]   clr_idx_i,
  output logic [NUM_SRC-1:0] flags_o
);
  logic [NUM_SRC-1:0] flag_q, clr_mask;

  assign clr_mask = clr_i ? (NUM_SRC'(1) << clr_idx_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_mask) | set_i;
  end

  assign flags_o = flag_q;

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i))) else $error("set lost"); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i[clr_idx_i]) |=> !flag_q[$past(clr_idx_i)]) else $error("ack no clear"); // R6
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NUM_SRC = intc_pkg::NUM_SRC,
  parameter int NUM_GRP = intc_pkg::NUM_GRP,
  parameter int NUM_LVL = intc_pkg::NUM_LVL,
  parameter int VEC_W   = $clog2(NUM_SRC),
  parameter int LVL_W   = $clog2(NUM_LVL),
  parameter int THR_W   = $clog2(NUM_LVL + 1)
) (
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               glb_i,
  input  logic [NUM_GRP-1:0] ip0_i,
  input  logic [NUM_GRP-1:0] ip1_i,
  input  logic [THR_W-1:0]   thr_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [LVL_W-1:0]   lvl_o
);
  import intc_pkg::*;

  logic             found;
  logic [LVL_W-1:0] best_lvl, cur_lvl;
  logic [VEC_W-1:0] best_vec;
  int               best_key, cur_key, grp;

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_vec = '0;
    best_key = 0;
    cur_lvl  = '0;
    cur_key  = 0;
    grp      = 0;
    for (int s = 0; s < NUM_SRC; s++) begin
      grp     = src_group(s);
      cur_lvl = {ip1_i[grp], ip0_i[grp]};
      cur_key = src_poll_key(s);
      if (flags_i[s] && en_i[s] && glb_i) begin
        if (!found || cur_lvl > best_lvl || (cur_lvl == best_lvl && cur_key < best_key)) begin
          found    = 1'b1;
          best_lvl = cur_lvl;
          best_vec = VEC_W'(s);
          best_key = cur_key;
        end
      end
    end
  end

  // threshold is 0 when idle, else top in-service level + 1
  assign irq_o = found && ((THR_W'(best_lvl) + THR_W'(1)) > thr_i);
  assign vec_o = best_vec;
  assign lvl_o = best_lvl;
endmodule

// File: rtl/intc_nest.sv
module intc_nest #(
  parameter int NUM_LVL = intc_pkg::NUM_LVL,
  parameter int LVL_W   = $clog2(NUM_LVL),
  parameter int THR_W   = $clog2(NUM_LVL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [THR_W-1:0] thr_o
);
  logic [NUM_LVL-1:0] ins_q, top_mask, push_mask;

  always_comb begin
    thr_o    = '0;
    top_mask = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (ins_q[l]) begin
        thr_o    = THR_W'(l + 1);
        top_mask = NUM_LVL'(1) << l;
      end
    end
  end

  assign push_mask = push_i ? (NUM_LVL'(1) << push_lvl_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ins_q <= '0;
    else         ins_q <= (ins_q & ~(pop_i ? top_mask : '0)) | push_mask;
  end

  AST_PUSH_ABOVE_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> ((THR_W'(push_lvl_i) + THR_W'(1)) > thr_o)) else $error("push not above top"); // R7
  AST_POP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && (|ins_q)) |=> ($countones(ins_q) == $countones($past(ins_q)) - 1)) else $error("pop"); // R8
endmodule

// File: rtl/intc_grp_prio.sv
module intc_grp_prio #(
  parameter int NUM_SRC = intc_pkg::NUM_SRC,
  parameter int NUM_GRP = intc_pkg::NUM_GRP,
  parameter int NUM_LVL = intc_pkg::NUM_LVL,
  parameter int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               sfr_wr_i,
  input  logic [7:0]         sfr_addr_i,
  input  logic [7:0]         sfr_wdata_i,
  output logic [7:0]         sfr_rdata_o,
  input  logic               ack_i,
  input  logic               reti_i,
  input  logic               stop_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic               wake_o
);
  localparam int LVL_W = $clog2(NUM_LVL);
  localparam int THR_W = $clog2(NUM_LVL + 1);

  logic [NUM_SRC-1:0] flags, en;
  logic               glb, take;
  logic [7:0]         ip0, ip1;
  logic [THR_W-1:0]   thr;
  logic [LVL_W-1:0]   win_lvl;

  assign take = ack_i && irq_o;

  intc_cfg_regs #(.NUM_SRC(NUM_SRC)) i_regs (
    .clk_i, .rst_ni, .wr_i(sfr_wr_i), .addr_i(sfr_addr_i), .wdata_i(sfr_wdata_i),
    .flags_i(flags), .rdata_o(sfr_rdata_o), .en_o(en), .glb_o(glb),
    .ip0_o(ip0), .ip1_o(ip1)
  );

  intc_flags #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) i_flags (
    .clk_i, .rst_ni, .set_i(src_i), .clr_i(take), .clr_idx_i(irq_vec_o), .flags_o(flags)
  );

  intc_arbiter #(.NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .NUM_LVL(NUM_LVL), .VEC_W(VEC_W)) i_arb (
    .flags_i(flags), .en_i(en), .glb_i(glb), .ip0_i(ip0[NUM_GRP-1:0]), .ip1_i(ip1[NUM_GRP-1:0]),
    .thr_i(thr), .irq_o, .vec_o(irq_vec_o), .lvl_o(win_lvl)
  );

  intc_nest #(.NUM_LVL(NUM_LVL)) i_nest (
    .clk_i, .rst_ni, .push_i(take), .push_lvl_i(win_lvl), .pop_i(reti_i), .thr_o(thr)
  );

  assign wake_o = stop_i && src_i[0];

  AST_IRQ_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags[irq_vec_o] && en[irq_vec_o] && glb)) else $error("ineligible irq"); // R3
  AST_ACK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !(|src_i)) |=> $stable(flags)) else $error("stray ack"); // R6
endmodule

// File: tb/test_intc_grp_prio.sv
module test_intc_grp_prio;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [10:0] src = '0;
  logic        wr = 1'b0, ack = 1'b0, reti = 1'b0, stop = 1'b0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        irq, wake;
  logic [3:0]  vec;

  int n_chk = 0, n_fail = 0;

  logic [10:0] m_flag, m_en;
  logic        m_glb;
  logic [7:0]  m_ip0, m_ip1;
  logic [3:0]  m_ins;

  always #10 clk = ~clk;

  intc_grp_prio i_intc_grp_prio (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .sfr_wr_i(wr), .sfr_addr_i(addr),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata), .ack_i(ack), .reti_i(reti), .stop_i(stop),
    .irq_o(irq), .irq_vec_o(vec), .wake_o(wake)
  );

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int grp_of(int s);
    case (s)
      0, 5, 6: return 0;
      1, 7:    return 1;
      2, 8:    return 2;
      3, 9:    return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int order_of(int s);
    case (s)
      0: return 0;  5: return 1;  6: return 2;
      1: return 3;  7: return 4;  2: return 5;
      8: return 6;  3: return 7;  9: return 8;
      4: return 9;  default: return 10;
    endcase
  endfunction

  // expected arbitration outcome from the model state
  task automatic exp_arb(output bit e_irq, output int e_vec, output int e_lvl);
    int top = -1;
    bit found = 0;
    e_vec = 0; e_lvl = 0;
    for (int l = 0; l < 4; l++) if (m_ins[l]) top = l;
    for (int s = 0; s < 11; s++) begin
      int g = grp_of(s);
      int lv = 2 * int'(m_ip1[g]) + int'(m_ip0[g]);
      if (m_flag[s] && m_en[s] && m_glb)
        if (!found || lv > e_lvl || (lv == e_lvl && order_of(s) < order_of(e_vec))) begin
          found = 1; e_lvl = lv; e_vec = s;
        end
    end
    e_irq = found && (e_lvl > top);
  endtask

  function automatic int exp_rd(logic [7:0] a);
    case (a)
      8'hA8: return {m_glb, m_en[6:0]};
      8'hB8: return {4'b0, m_en[10:7]};
      8'hA9: return m_ip0;
      8'hB9: return m_ip1;
      8'hC0: return m_flag[7:0];
      8'hC1: return {5'b0, m_flag[10:8]};
      default: return 0;
    endcase
  endfunction

  task automatic cyc(input logic [10:0] s, input bit w, input logic [7:0] a,
                     input logic [7:0] d, input bit k, input bit r, input bit st);
    bit e_irq; int e_vec, e_lvl;
    @(negedge clk);
    src = s; wr = w; addr = a; wdata = d; ack = k; reti = r; stop = st;
    #2;
    exp_arb(e_irq, e_vec, e_lvl);
    check("R7 irq", int'(irq), int'(e_irq));
    if (e_irq) check("R5 vector", int'(vec), e_vec);
    check("R11 read", int'(rdata), exp_rd(a));
    check("R10 wake", int'(wake), int'(st && s[0]));
    @(posedge clk);
    if (k && e_irq) m_flag[e_vec] = 1'b0;
    m_flag |= s;
    if (r) for (int l = 3; l >= 0; l--) if (m_ins[l]) begin m_ins[l] = 1'b0; break; end
    if (k && e_irq) m_ins[e_lvl] = 1'b1;
    if (w) case (a)
      8'hA8: begin m_en[6:0] = d[6:0]; m_glb = d[7]; end
      8'hB8: m_en[10:7] = d[3:0];
      8'hA9: m_ip0 = d;
      8'hB9: m_ip1 = d;
      default: ;
    endcase
  endtask

  task automatic peek(input logic [7:0] a);
    @(negedge clk);
    src = '0; wr = 0; addr = a; wdata = '0; ack = 0; reti = 0; stop = 0;
    #2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1217));
    m_flag = '0; m_en = '0; m_glb = 0; m_ip0 = '0; m_ip1 = '0; m_ins = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    peek(8'hA8); check("R1 irq", int'(irq), 0); check("R1 en0", int'(rdata), 0);
    peek(8'hA9); check("R1 ip0", int'(rdata), 0);
    peek(8'hB9); check("R1 ip1", int'(rdata), 0);
    peek(8'hC0); check("R1 flags", int'(rdata), 0);

    // R3 global gate
    cyc('0, 1, 8'hA8, 8'h7F, 0, 0, 0);
    cyc(11'h001, 0, 8'h00, 8'h00, 0, 0, 0);
    peek(8'hC0); check("R2 flag set", int'(rdata[0]), 1); check("R3 global off", int'(irq), 0);
    cyc('0, 1, 8'hA8, 8'hFF, 0, 0, 0);
    peek(8'h00); check("R3 enabled irq", int'(irq), 1); check("R3 vec", int'(vec), 0);
    check("R11 unmapped", int'(rdata), 0);

    // R6/R7: take ext0 at level 0, then same-level requests stay blocked
    cyc('0, 1, 8'hB8, 8'h0F, 1, 0, 0);
    cyc(11'h0E0, 0, 8'h00, 8'h00, 0, 0, 0);
    peek(8'hC0); check("R6 flag cleared", int'(rdata[0]), 0); check("R7 blocked", int'(irq), 0);
    // R8 return exposes them, R5 polling picks serial1
    cyc('0, 0, 8'h00, 8'h00, 0, 1, 0);
    peek(8'h00); check("R8 after reti", int'(irq), 1); check("R5 poll", int'(vec), 5);

    // R4/R9: group1 to level 1 with bit 6 set as well
    cyc('0, 1, 8'hA9, 8'h42, 0, 0, 0);
    peek(8'hA9); check("R9 readback", int'(rdata), 8'h42); check("R4 level win", int'(vec), 7);
    cyc('0, 0, 8'h00, 8'h00, 1, 0, 0);
    peek(8'h00); check("R7 nested block", int'(irq), 0);
    // R6 ack without irq ignored
    cyc('0, 0, 8'h00, 8'h00, 1, 0, 0);
    peek(8'hC0); check("R6 stray ack", int'(rdata), 8'h60);
    cyc('0, 0, 8'h00, 8'h00, 0, 1, 0);
    // R2 strobe beats ack on the same source
    cyc(11'h020, 0, 8'h00, 8'h00, 1, 0, 0);
    peek(8'hC0); check("R2 set wins", int'(rdata[5]), 1);
    // R11 flag register not writable, R9 bit 7 of IP1 ignored
    cyc('0, 1, 8'hC0, 8'h00, 0, 0, 0);
    cyc('0, 1, 8'hB9, 8'hC0, 0, 0, 0);
    peek(8'hC0); check("R11 flag write ignored", int'(rdata), 8'h60);
    // R10 wake
    cyc(11'h001, 0, 8'h00, 8'h00, 0, 0, 1);
    cyc(11'h000, 0, 8'h00, 8'h00, 0, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      logic [10:0] s = '0;
      logic [7:0] a;
      bit w, k, r;
      for (int b = 0; b < 11; b++) s[b] = ($urandom_range(0, 9) == 0);
      case ($urandom_range(0, 7))
        0: a = 8'hA8; 1: a = 8'hB8; 2: a = 8'hA9; 3: a = 8'hB9;
        4: a = 8'hC0; 5: a = 8'hC1; default: a = 8'($urandom);
      endcase
      w = ($urandom_range(0, 5) == 0);
      k = ($urandom_range(0, 2) != 0);
      r = ($urandom_range(0, 5) == 0);
      cyc(s, w, a, 8'($urandom), k, r, ($urandom_range(0, 3) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule